// File: doc/BRIEF.md
# Serial Transmit Command and Start Controller

This block sits on the transmit side of a serial communications channel. It takes one-shot command strobes written by the host (transmitter on, transmitter off, transmitter reset, transmit frame with an optional end-of-message flag). It also takes XON/XOFF indications from a receive-side character detector. From these inputs it decides when bytes may leave a 32-entry transmit FIFO. Its outputs are a transmit-enable gate for the serial shifter, a FIFO clear and a protocol-engine reset, a start-of-frame request (so that downstream logic can put an opening flag in front of the data), an end-of-frame tag on the final byte, and a byte request towards a DMA engine.

The block has two operating modes. In host-driven mode, the frame command releases the bytes the host has already placed in the FIFO. In DMA mode, the frame command arms a block transfer whose length comes from a programmed 12-bit count. Serial output then begins at whichever comes first: the FIFO filling up, or the whole block being delivered. In-band flow control is optional. When it is enabled, the host on/off commands act exactly like received XON/XOFF characters.

Top module: `txc_top`

## Requirements
- R1: Every command is a single-cycle strobe qualified by `cmd_wr`. One write produces exactly one cycle of `fifo_clr`/`proto_rst`, or of `sof_req`, and never a repeated pulse.
- R2: With flow control enabled, a transmitter-off command or `rx_xoff` closes the gate: `tx_enable` is 0 from the cycle after the strobe.
- R3: With flow control enabled, a transmitter-on command or `rx_xon` reopens the gate in the cycle after the strobe. If on and off requests arrive in the same cycle, off wins.
- R4: With flow control disabled, on/off commands and `rx_xon`/`rx_xoff` have no effect and the gate stays open.
- R5: A transmitter-reset command, in any mode, pulses `fifo_clr` and `proto_rst` for one cycle. It ends any frame (`tx_enable` drops), returns flow control to the on state and clears `xf_err`.
- R6: In host-driven mode (`cfg_dma_mode`=0), a frame command with `fifo_level` nonzero sets `tx_enable` in the next cycle. With an empty FIFO the command is ignored.
- R7: When `cfg_packet`=1, one `sof_req` pulse marks the start of serial output for each frame. When `cfg_packet`=0, no `sof_req` is produced.
- R8: If the end-of-message bit accompanied the frame command, `eof_mark` is high in the same cycle as the pop of the frame's last byte. The last byte is the pop at `fifo_level`=1 in host-driven mode, and the pop that reaches the count in DMA mode. After that pop `tx_enable` is 0.
- R9: In DMA mode the frame command does not open `tx_enable` on its own. It raises `dma_req`, which stays high until the programmed number of `dma_byte_wr` strobes has been accepted.
- R10: In DMA mode, serial output starts in the cycle after `fifo_level` reaches 32 or the delivered byte count equals the programmed count, whichever comes first.
- R11: In DMA mode a programmed count of zero starts nothing: no `dma_req`, no `sof_req`, no `tx_enable`.
- R12: A frame command received while a frame is in progress is ignored, and it sets the sticky `xf_err`. Only a transmitter reset clears `xf_err`.
- R13: After reset, `tx_enable`, `fifo_clr`, `proto_rst`, `sof_req`, `eof_mark`, `dma_req` and `xf_err` are all 0, and flow control is in the on state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_flow_en | input | 1 | In-band flow control enabled |
| cfg_dma_mode | input | 1 | 1 = DMA mode, 0 = host-driven mode |
| cfg_packet | input | 1 | Packet protocol selected (opening flag wanted) |
| cmd_wr | input | 1 | Command write strobe |
| cmd_txon | input | 1 | Transmitter-on command bit |
| cmd_txoff | input | 1 | Transmitter-off command bit |
| cmd_xres | input | 1 | Transmitter-reset command bit |
| cmd_xf | input | 1 | Transmit-frame command bit |
| cmd_xme | input | 1 | End-of-message bit, used together with the frame command |
| rx_xon | input | 1 | XON character detected by the receiver |
| rx_xoff | input | 1 | XOFF character detected by the receiver |
| dma_len | input | 12 | Programmed DMA block length in bytes |
| dma_byte_wr | input | 1 | DMA engine wrote one byte into the FIFO |
| fifo_level | input | 6 | Current FIFO fill level, 0 to 32 |
| tx_pop | input | 1 | Serial shifter takes one byte |
| tx_enable | output | 1 | Gate that lets the shifter pop bytes |
| fifo_clr | output | 1 | One-cycle FIFO clear |
| proto_rst | output | 1 | One-cycle protocol engine reset |
| sof_req | output | 1 | One-cycle start-of-frame request |
| eof_mark | output | 1 | Tags the byte popped this cycle as end of frame |
| dma_req | output | 1 | DMA byte request |
| xf_err | output | 1 | Sticky frame-command-while-busy error |

## Verification
The properties assume that `fifo_level` stays between 0 and 32 and follows the FIFO's real writes and pops. They also assume that `tx_pop` is asserted only while `tx_enable` is high, and that `dma_byte_wr` arrives only while `dma_req` is high. The mode inputs are assumed stable for the whole of a frame. The stimulus keeps to these rules: the bench keeps its own model of the FIFO fill level, and it updates that level at the same edge as every write or pop it drives. It pops only while the gate is open, and it changes configuration only between frames or right after a transmitter reset.

// File: rtl/txc_pkg.sv
package txc_pkg;
    localparam int FIFO_DEPTH = 32;
    localparam int CNT_W      = 12;
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        logic flow_on;
    } flow_st_t;

    typedef struct packed {
        logic clr;
    } cmd_st_t;

    typedef struct packed {
        logic             busy;
        logic             started;
        logic             dma;
        logic             xme;
        logic             packet;
        logic [CNT_W-1:0] len;
        logic [CNT_W-1:0] wr_cnt;
        logic [CNT_W-1:0] pop_cnt;
        logic             sof;
        logic             err;
    } frame_st_t;
endpackage

// File: rtl/txc_cmd_dec.sv
module txc_cmd_dec (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  logic cmd_txon,
    input  logic cmd_txoff,
    input  logic cmd_xres,
    input  logic cmd_xf,
    input  logic rx_xon,
    input  logic rx_xoff,
    output logic xres_s,
    output logic xf_s,
    output logic on_req,
    output logic off_req,
    output logic clr_pulse
);
    import txc_pkg::*;

    cmd_st_t st_d, st_q;

    // Strobes live for the write cycle only; nothing is held.
    always_comb begin
        xres_s   = cmd_wr & cmd_xres;
        xf_s     = cmd_wr & cmd_xf;
        on_req   = (cmd_wr & cmd_txon) | rx_xon;
        off_req  = (cmd_wr & cmd_txoff) | rx_xoff;
        st_d     = st_q;
        st_d.clr = xres_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clr_pulse = st_q.clr;
endmodule

// File: rtl/txc_flow.sv
module txc_flow (
    input  logic clk,
    input  logic rst_n,
    input  logic flow_en,
    input  logic xres_s,
    input  logic on_req,
    input  logic off_req,
    output logic flow_open
);
    import txc_pkg::*;

    flow_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (xres_s) begin
            st_d.flow_on = 1'b1;
        end else if (flow_en) begin
            if (off_req)     st_d.flow_on = 1'b0;
            else if (on_req) st_d.flow_on = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{flow_on: 1'b1};
        else        st_q <= st_d;
    end

    assign flow_open = ~flow_en | st_q.flow_on;
endmodule

// File: rtl/txc_frame.sv
module txc_frame #(
    parameter int DEPTH = txc_pkg::FIFO_DEPTH,
    parameter int CW    = txc_pkg::CNT_W,
    parameter int LW    = txc_pkg::LVL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xres_s,
    input  logic          xf_s,
    input  logic          xme,
    input  logic          dma_mode,
    input  logic          packet,
    input  logic [CW-1:0] dma_len,
    input  logic          dma_byte_wr,
    input  logic [LW-1:0] fifo_level,
    input  logic          tx_pop,
    input  logic          flow_open,
    output logic          tx_enable,
    output logic          sof_req,
    output logic          eof_mark,
    output logic          dma_req,
    output logic          xf_err
);
    import txc_pkg::*;

    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
    localparam logic [LW-1:0] ONE_LVL  = LW'(1);

    frame_st_t st_d, st_q;
    logic      running;
    logic      pop_ok;
    logic      last_byte;
    logic      accept;
    logic      start_cond;

    always_comb begin
        running    = st_q.busy & st_q.started;
        pop_ok     = tx_pop & running & flow_open;
        last_byte  = st_q.dma ? ((st_q.pop_cnt + CW'(1)) == st_q.len)
                              : (fifo_level == ONE_LVL);
        start_cond = (fifo_level >= FULL_LVL) | (st_q.wr_cnt == st_q.len);
        accept     = xf_s & ~st_q.busy &
                     (dma_mode ? (dma_len != '0) : (fifo_level != '0));

        st_d     = st_q;
        st_d.sof = 1'b0;

        if (xres_s) begin
            st_d = '0;
        end else begin
            if (st_q.busy) begin
                if (st_q.dma && dma_byte_wr && (st_q.wr_cnt < st_q.len))
                    st_d.wr_cnt = st_q.wr_cnt + CW'(1);
                if (st_q.dma && !st_q.started && start_cond) begin
                    st_d.started = 1'b1;
                    st_d.sof     = st_q.packet;
                end
                if (pop_ok) begin
                    st_d.pop_cnt = st_q.pop_cnt + CW'(1);
                    if (last_byte) begin
                        st_d.busy    = 1'b0;
                        st_d.started = 1'b0;
                        st_d.dma     = 1'b0;
                    end
                end
                if (xf_s) st_d.err = 1'b1;
            end
            if (accept) begin
                st_d.busy    = 1'b1;
                st_d.dma     = dma_mode;
                st_d.started = ~dma_mode;
                st_d.xme     = xme;
                st_d.packet  = packet;
                st_d.len     = dma_len;
                st_d.wr_cnt  = '0;
                st_d.pop_cnt = '0;
                st_d.sof     = packet & ~dma_mode;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_enable = running & flow_open;
    assign sof_req   = st_q.sof;
    assign eof_mark  = pop_ok & last_byte & st_q.xme;
    assign dma_req   = st_q.busy & st_q.dma & (st_q.wr_cnt < st_q.len);
    assign xf_err    = st_q.err;
endmodule

// File: rtl/txc_top.sv
module txc_top #(
    parameter int DEPTH = txc_pkg::FIFO_DEPTH,
    parameter int CW    = txc_pkg::CNT_W,
    parameter int LW    = txc_pkg::LVL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_flow_en,
    input  logic          cfg_dma_mode,
    input  logic          cfg_packet,
    input  logic          cmd_wr,
    input  logic          cmd_txon,
    input  logic          cmd_txoff,
    input  logic          cmd_xres,
    input  logic          cmd_xf,
    input  logic          cmd_xme,
    input  logic          rx_xon,
    input  logic          rx_xoff,
    input  logic [CW-1:0] dma_len,
    input  logic          dma_byte_wr,
    input  logic [LW-1:0] fifo_level,
    input  logic          tx_pop,
    output logic          tx_enable,
    output logic          fifo_clr,
    output logic          proto_rst,
    output logic          sof_req,
    output logic          eof_mark,
    output logic          dma_req,
    output logic          xf_err
);
    logic xres_s, xf_s, on_req, off_req, clr_pulse, flow_open;

    txc_cmd_dec u_dec (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr),
        .cmd_txon(cmd_txon), .cmd_txoff(cmd_txoff), .cmd_xres(cmd_xres),
        .cmd_xf(cmd_xf), .rx_xon(rx_xon), .rx_xoff(rx_xoff),
        .xres_s(xres_s), .xf_s(xf_s), .on_req(on_req), .off_req(off_req),
        .clr_pulse(clr_pulse)
    );

    txc_flow u_flow (
        .clk(clk), .rst_n(rst_n), .flow_en(cfg_flow_en), .xres_s(xres_s),
        .on_req(on_req), .off_req(off_req), .flow_open(flow_open)
    );

    txc_frame #(.DEPTH(DEPTH), .CW(CW), .LW(LW)) u_frame (
        .clk(clk), .rst_n(rst_n), .xres_s(xres_s), .xf_s(xf_s),
        .xme(cmd_xme), .dma_mode(cfg_dma_mode), .packet(cfg_packet),
        .dma_len(dma_len), .dma_byte_wr(dma_byte_wr),
        .fifo_level(fifo_level), .tx_pop(tx_pop), .flow_open(flow_open),
        .tx_enable(tx_enable), .sof_req(sof_req), .eof_mark(eof_mark),
        .dma_req(dma_req), .xf_err(xf_err)
    );

    assign fifo_clr  = clr_pulse;
    assign proto_rst = clr_pulse;
endmodule

// File: rtl/txc_checker.sv
module txc_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_flow_en,
    input logic cmd_wr,
    input logic cmd_txoff,
    input logic cmd_xres,
    input logic rx_xoff,
    input logic tx_enable,
    input logic fifo_clr,
    input logic proto_rst,
    input logic sof_req,
    input logic xf_err
);
    logic xres_w;
    assign xres_w = cmd_wr & cmd_xres;

    // R2: an off request under flow control closes the gate next cycle
    a_r2_off_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_flow_en && (rx_xoff || (cmd_wr && cmd_txoff)) && !xres_w) |=> !tx_enable);

    // R5: reset command yields clear and protocol reset, gate shut
    a_r5_xres_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        xres_w |=> (fifo_clr && proto_rst && !tx_enable));

    // R1: the clear pulse lasts one cycle unless the command is repeated
    a_r1_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_clr && !xres_w) |=> !fifo_clr);

    // R1: start-of-frame request is a single-cycle pulse
    a_r1_sof_single: assert property (@(posedge clk) disable iff (!rst_n)
        sof_req |=> !sof_req);

    // R12: error flag holds until a transmitter reset
    a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (xf_err && !xres_w) |=> xf_err);
endmodule

bind txc_top txc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_flow_en(cfg_flow_en), .cmd_wr(cmd_wr),
    .cmd_txoff(cmd_txoff), .cmd_xres(cmd_xres), .rx_xoff(rx_xoff),
    .tx_enable(tx_enable), .fifo_clr(fifo_clr), .proto_rst(proto_rst),
    .sof_req(sof_req), .xf_err(xf_err)
);

// File: tb/test_txc_top.sv
module test_txc_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_flow_en = 0, cfg_dma_mode = 0, cfg_packet = 0;
    logic        cmd_wr = 0, cmd_txon = 0, cmd_txoff = 0, cmd_xres = 0, cmd_xf = 0, cmd_xme = 0;
    logic        rx_xon = 0, rx_xoff = 0;
    logic [11:0] dma_len = '0;
    logic        dma_byte_wr = 0;
    logic [5:0]  fifo_level = '0;
    logic        tx_pop = 0;
    logic        tx_enable, fifo_clr, proto_rst, sof_req, eof_mark, dma_req, xf_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    byte exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    txc_top i_txc_top (
        .clk(clk), .rst_n(rst_n), .cfg_flow_en(cfg_flow_en), .cfg_dma_mode(cfg_dma_mode),
        .cfg_packet(cfg_packet), .cmd_wr(cmd_wr), .cmd_txon(cmd_txon), .cmd_txoff(cmd_txoff),
        .cmd_xres(cmd_xres), .cmd_xf(cmd_xf), .cmd_xme(cmd_xme), .rx_xon(rx_xon),
        .rx_xoff(rx_xoff), .dma_len(dma_len), .dma_byte_wr(dma_byte_wr),
        .fifo_level(fifo_level), .tx_pop(tx_pop), .tx_enable(tx_enable),
        .fifo_clr(fifo_clr), .proto_rst(proto_rst), .sof_req(sof_req),
        .eof_mark(eof_mark), .dma_req(dma_req), .xf_err(xf_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr_cmd(input bit on, input bit off, input bit xres, input bit xf, input bit xme);
        cmd_wr = 1; cmd_txon = on; cmd_txoff = off; cmd_xres = xres; cmd_xf = xf; cmd_xme = xme;
        tick();
        cmd_wr = 0; cmd_txon = 0; cmd_txoff = 0; cmd_xres = 0; cmd_xf = 0; cmd_xme = 0;
    endtask

    // driver: pushes the end-of-frame expectation ahead of the final pop
    task automatic pop_n(input int n, input bit tag_last);
        for (int i = 0; i < n; i++) begin
            if (tag_last && i == n - 1) exp_q.push_back("E");
            tx_pop = 1;
            tick();
            fifo_level = fifo_level - 6'd1;
            tx_pop = 0;
        end
    endtask

    task automatic dma_fill(input int n);
        for (int i = 0; i < n; i++) begin
            dma_byte_wr = 1;
            tick();
            fifo_level = fifo_level + 6'd1;
            dma_byte_wr = 0;
        end
    endtask

    // monitor: every pulse must match the next queued expectation (R7, R8)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (sof_req) begin
                n_chk++;
                if (exp_q.size() == 0 || exp_q[0] != "S") begin
                    n_fail++;
                    $display("FAIL R7 actual=sof_req expected=%s",
                             exp_q.size() == 0 ? "none" : "other");
                end
                if (exp_q.size() != 0) void'(exp_q.pop_front());
            end
            if (eof_mark) begin
                n_chk++;
                if (exp_q.size() == 0 || exp_q[0] != "E") begin
                    n_fail++;
                    $display("FAIL R8 actual=eof_mark expected=%s",
                             exp_q.size() == 0 ? "none" : "other");
                end
                if (exp_q.size() != 0) void'(exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R13 tx_enable", tx_enable, 0);
        chk("R13 clr/rst", {fifo_clr, proto_rst}, 0);
        chk("R13 sof/eof/dma/err", {sof_req, eof_mark, dma_req, xf_err}, 0);
        rst_n = 1;
        tick();

        // host-driven packet frame with end of message
        cfg_packet = 1; fifo_level = 3;
        exp_q.push_back("S");
        wr_cmd(0, 0, 0, 1, 1);
        chk("R6 start", tx_enable, 1);
        pop_n(3, 1);
        chk("R8 frame over", tx_enable, 0);

        // empty FIFO: frame command ignored
        wr_cmd(0, 0, 0, 1, 0);
        chk("R6 empty ignored", tx_enable, 0);
        chk("R12 no err when idle", xf_err, 0);

        // non-packet: no sof, no eof without xme
        cfg_packet = 0; fifo_level = 2;
        wr_cmd(0, 0, 0, 1, 0);
        chk("R7 nonpacket start", tx_enable, 1);
        pop_n(2, 0);

        // flow control on/off
        cfg_flow_en = 1; cfg_packet = 1; fifo_level = 4;
        exp_q.push_back("S");
        wr_cmd(0, 0, 0, 1, 0);
        chk("R6 flow frame", tx_enable, 1);
        wr_cmd(0, 1, 0, 0, 0);
        chk("R2 cmd off", tx_enable, 0);
        wr_cmd(1, 0, 0, 0, 0);
        chk("R3 cmd on", tx_enable, 1);
        rx_xoff = 1; tick(); rx_xoff = 0;
        chk("R2 rx xoff", tx_enable, 0);
        rx_xon = 1; tick(); rx_xon = 0;
        chk("R3 rx xon", tx_enable, 1);
        rx_xon = 1; wr_cmd(0, 1, 0, 0, 0); rx_xon = 0;
        chk("R3 off wins", tx_enable, 0);
        rx_xon = 1; tick(); rx_xon = 0;
        pop_n(4, 0);
        chk("R8 flow frame over", tx_enable, 0);

        // flow disabled, busy error, reset
        cfg_flow_en = 0; cfg_packet = 0; fifo_level = 2;
        wr_cmd(0, 0, 0, 1, 0);
        wr_cmd(0, 1, 0, 0, 0);
        chk("R4 cmd off ignored", tx_enable, 1);
        rx_xoff = 1; tick(); rx_xoff = 0;
        chk("R4 rx xoff ignored", tx_enable, 1);
        wr_cmd(0, 0, 0, 1, 0);
        chk("R12 err set", xf_err, 1);
        chk("R12 frame unaffected", tx_enable, 1);
        pop_n(1, 0);
        chk("R12 err sticky", xf_err, 1);
        wr_cmd(0, 0, 1, 0, 0);
        fifo_level = 0;
        chk("R5 clear", {fifo_clr, proto_rst}, 2'b11);
        chk("R5 gate shut", tx_enable, 0);
        chk("R5 err cleared", xf_err, 0);
        tick();
        chk("R1 clear single cycle", fifo_clr, 0);

        // reset returns flow to on
        cfg_flow_en = 1; fifo_level = 3;
        wr_cmd(0, 0, 0, 1, 0);
        rx_xoff = 1; tick(); rx_xoff = 0;
        chk("R2 off before reset", tx_enable, 0);
        wr_cmd(0, 0, 1, 0, 0);
        fifo_level = 3;
        wr_cmd(0, 0, 0, 1, 0);
        chk("R5 flow back on", tx_enable, 1);
        pop_n(3, 0);
        cfg_flow_en = 0;

        // DMA, short block: start at count
        cfg_dma_mode = 1; cfg_packet = 1; dma_len = 12'd5; fifo_level = 0;
        wr_cmd(0, 0, 0, 1, 1);
        chk("R9 no immediate start", tx_enable, 0);
        chk("R9 dma_req", dma_req, 1);
        dma_fill(5);
        chk("R9 dma_req done", dma_req, 0);
        exp_q.push_back("S");
        tick();
        chk("R10 start at count", tx_enable, 1);
        pop_n(5, 1);
        chk("R8 dma frame over", tx_enable, 0);

        // DMA, long block: start at full FIFO
        cfg_packet = 1; dma_len = 12'd40;
        wr_cmd(0, 0, 0, 1, 0);
        dma_fill(31);
        chk("R10 not yet", tx_enable, 0);
        dma_fill(1);
        exp_q.push_back("S");
        tick();
        chk("R10 start at full", tx_enable, 1);
        chk("R9 still requesting", dma_req, 1);
        for (int i = 0; i < 8; i++) begin
            tx_pop = 1; dma_byte_wr = 1;
            tick();
            tx_pop = 0; dma_byte_wr = 0;
        end
        chk("R9 request over", dma_req, 0);
        pop_n(32, 0);
        chk("R8 long frame over", tx_enable, 0);

        // DMA zero count
        dma_len = 12'd0;
        wr_cmd(0, 0, 0, 1, 0);
        chk("R11 no dma_req", dma_req, 0);
        tick(); tick();
        chk("R11 no start", tx_enable, 0);

        chk("R7 scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule